// File: doc/BRIEF.md
# Backlash Gap Computation Unit

This block measures the instantaneous lost motion in a geared drive. It takes two position samples. One is a signed motor-side encoder count. The other is a 16-bit absolute load-side angle, where a full load revolution is 65536 LSBs. The unit multiplies the motor count by a programmable electronic gear ratio to form the load angle that a drive with no play would reach. It then subtracts that ideal angle from the measured load angle. The difference is a signed gap in load-angle LSBs.

The ratio is an unsigned fixed-point number with 8 integer bits and 16 fraction bits. It is written through a one-cycle configuration strobe. For example, a 2000-count motor encoder with a 1:1 gear needs a ratio of 65536/2000. A zeroing sequence aligns the two position scales. Software arms the unit, and the next paired sample whose load angle reads exactly zero records the motor count as the motor origin. Later products use the motor count relative to that origin.

Top module: `backlash_gap_unit`

## Requirements
- R1: After reset `gap_valid` is 0, `gap` is 0, the ratio is 1.0 (0x010000) and the motor origin is 0.
- R2: `gap_valid` is 1 in the cycle after a rising edge where `mot_valid` and `load_valid` are both 1, and 0 after every other edge.
- R3: The result is `gap = (load_angle - ideal) mod 2^16`, read as a signed 16-bit value. `ideal` is the low 16 bits of round((mot_count - origin) * ratio / 2^16).
- R4: Rounding is to nearest, with exact halves rounded toward positive infinity. With ratio 0x008000, a relative count of +1 gives ideal 1 and a count of -1 gives ideal 0.
- R5: The subtraction wraps modulo 2^16. A load angle of 5 against an ideal of 65530 yields +11, and a load angle of 65530 against an ideal of 5 yields -11.
- R6: A cycle with `cfg_ratio_we`=1 loads `cfg_ratio` as the ratio. Bits 23:16 hold the integer part and bits 15:0 the fraction. A pair sampled in the write cycle still uses the old ratio, and pairs in later cycles use the new one.
- R7: A sample on only one input produces no result. `gap` keeps its last value until the next paired sample.
- R8: A `zero_arm` pulse arms the zeroing. The first later pair with `load_angle`==0 stores `mot_count` as the origin and disarms the unit. That pair outputs gap 0. While armed, pairs with a nonzero load angle use the previous origin.
- R9: Negative relative motor counts scale correctly under signed arithmetic across the whole configured count width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio_we | input | 1 | Ratio write strobe |
| cfg_ratio | input | 24 | Unsigned Q8.16 gear ratio |
| zero_arm | input | 1 | Arms origin capture at the next zero load angle |
| mot_valid | input | 1 | Motor count sample is valid |
| mot_count | input | 24 | Signed motor encoder count |
| load_valid | input | 1 | Load angle sample is valid |
| load_angle | input | 16 | Unsigned load angle, 65536 LSB per revolution |
| gap_valid | output | 1 | Result strobe |
| gap | output | 16 | Signed gap in load-angle LSBs |

## Verification
The assertions assume that the configuration, arm and sample strobes are synchronous single-cycle levels. They also assume that a sample becomes a result only when both sources present it in the same cycle, and that the 24-bit motor count does not overflow its relative difference. The bench changes inputs only on falling edges. It keeps relative counts far inside the signed range. It sweeps motor counts of both signs, several ratios (including the extremes 1 LSB and 0xFFFFFF), and load angles near the 0/65535 seam. These cases exercise the rounding, the wrap and the zeroing paths.

// File: rtl/backlash_gap_unit.sv
module backlash_gap_unit #(
  parameter int CNT_W     = 24,
  parameter int ANG_W     = 16,
  parameter int RATIO_INT = 8,
  parameter int FRAC      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_ratio_we,
  input  logic [RATIO_INT+FRAC-1:0] cfg_ratio,
  input  logic                    zero_arm,
  input  logic                    mot_valid,
  input  logic signed [CNT_W-1:0] mot_count,
  input  logic                    load_valid,
  input  logic [ANG_W-1:0]        load_angle,
  output logic                    gap_valid,
  output logic signed [ANG_W-1:0] gap
);
  localparam int RW = RATIO_INT + FRAC;
  localparam int PW = CNT_W + RW + 2;
  localparam logic [RW-1:0] RATIO_ONE = RW'(1) << FRAC;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic [RW-1:0]            ratio_q;
  logic signed [CNT_W-1:0]  origin_q;
  logic                     armed_q;

  wire pair    = mot_valid && load_valid;
  wire capture = pair && armed_q && (load_angle == '0);

  logic signed [CNT_W-1:0] eff_origin;
  logic signed [CNT_W:0]   rel;
  logic signed [PW-1:0]    prod, prod_r;
  logic [ANG_W-1:0]        ideal;

  assign eff_origin = capture ? mot_count : origin_q;
  assign rel    = $signed({mot_count[CNT_W-1], mot_count}) - $signed({eff_origin[CNT_W-1], eff_origin});
  assign prod   = PW'(rel) * $signed(PW'({1'b0, ratio_q}));
  assign prod_r = prod + HALF;
  assign ideal  = prod_r[FRAC +: ANG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q   <= RATIO_ONE;
      origin_q  <= '0;
      armed_q   <= 1'b0;
      gap_valid <= 1'b0;
      gap       <= '0;
    end else begin
      if (cfg_ratio_we) ratio_q <= cfg_ratio;
      if (capture) origin_q <= mot_count;
      if (zero_arm) armed_q <= 1'b1;
      else if (capture) armed_q <= 1'b0;
      gap_valid <= pair;
      if (pair) gap <= $signed(load_angle - ideal);
    end
  end

  a_r2_result_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pair |=> gap_valid);
  a_r2_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    !pair |=> !gap_valid);
  a_r7_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pair |=> $stable(gap));
  a_r6_ratio_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ratio_we |=> $stable(ratio_q));
  a_r8_origin_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (origin_q == $past(mot_count)) && (gap == '0));
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !zero_arm) |=> !armed_q);
endmodule

// File: tb/sim_backlash_gap_unit.sv
module sim_backlash_gap_unit;
  logic clk = 0, rst_n = 0;
  logic cfg_ratio_we = 0, zero_arm = 0, mot_valid = 0, load_valid = 0;
  logic [23:0] cfg_ratio = 0;
  logic signed [23:0] mot_count = 0;
  logic [15:0] load_angle = 0;
  logic gap_valid;
  logic signed [15:0] gap;
  int checks = 0, errors = 0;
  longint m_ratio = 64'h10000, m_origin = 0;
  logic signed [15:0] last_gap = 0;

  always #10 clk = ~clk;

  backlash_gap_unit u0 (.clk, .rst_n, .cfg_ratio_we, .cfg_ratio, .zero_arm,
    .mot_valid, .mot_count, .load_valid, .load_angle, .gap_valid, .gap);

  function automatic logic signed [15:0] ref_gap(longint m, longint o, longint r, longint l);
    longint p, q;
    logic [15:0] id;
    p = (m - o) * r;
    q = (p + 32768) >>> 16;
    id = q[15:0];
    return $signed(16'(l) - id);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ratio(logic [23:0] r);
    @(negedge clk);
    cfg_ratio_we = 1; cfg_ratio = r;
    @(negedge clk);
    cfg_ratio_we = 0;
    m_ratio = r;
  endtask

  task automatic pair(longint m, longint l, string req);
    logic signed [15:0] e;
    @(negedge clk);
    mot_valid = 1; load_valid = 1; mot_count = 24'(m); load_angle = 16'(l);
    e = ref_gap(m, m_origin, m_ratio, l);
    @(posedge clk); #1;
    mot_valid = 0; load_valid = 0;
    chk({req, " valid"}, gap_valid, 1);
    chk(req, gap, e);
    last_gap = e;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint rl[5] = '{64'h10000, 64'h8000, 2147484, 1, 64'hFFFFFF};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 gap_valid", gap_valid, 0);
    chk("R1 gap", gap, 0);
    rst_n = 1;
    pair(1234, 1300, "R1 unity ratio");

    foreach (rl[i]) begin
      set_ratio(rl[i][23:0]);
      for (int m = -300; m <= 300; m += 7)
        pair(m, (m * 37 + 65500) & 16'hFFFF, "R3/R9 sweep");
    end
    pair(-8000000, 12, "R9 large negative");
    pair(8000000, 40000, "R9 large positive");

    set_ratio(24'h008000);
    pair(1, 0, "R4 half up");
    chk("R4 ideal +0.5", gap, -1);
    pair(-1, 0, "R4 half down");
    chk("R4 ideal -0.5", gap, 0);
    pair(3, 0, "R4 1.5");
    chk("R4 ideal 1.5", gap, -2);

    set_ratio(24'h010000);
    pair(-6, 5, "R5 wrap");
    chk("R5 plus 11", gap, 11);
    pair(5, 65530, "R5 wrap");
    chk("R5 minus 11", gap, -11);

    @(negedge clk);
    mot_valid = 1; mot_count = 999;
    @(posedge clk); #1;
    chk("R7 lone motor valid", gap_valid, 0);
    chk("R7 gap held", gap, last_gap);
    @(negedge clk);
    mot_valid = 0; load_valid = 1; load_angle = 77;
    @(posedge clk); #1;
    chk("R7 lone load valid", gap_valid, 0);
    chk("R7 gap held", gap, last_gap);
    load_valid = 0;

    @(negedge clk);
    cfg_ratio_we = 1; cfg_ratio = 24'h020000;
    mot_valid = 1; load_valid = 1; mot_count = 10; load_angle = 100;
    @(posedge clk); #1;
    chk("R6 write cycle old ratio", gap, 90);
    cfg_ratio_we = 0; mot_valid = 0; load_valid = 0;
    m_ratio = 64'h20000;
    pair(10, 100, "R6 new ratio");
    chk("R6 doubled", gap, 80);

    @(negedge clk);
    zero_arm = 1;
    @(negedge clk);
    zero_arm = 0;
    pair(500, 50, "R8 armed nonzero uses old origin");
    @(negedge clk);
    mot_valid = 1; load_valid = 1; mot_count = 700; load_angle = 0;
    @(posedge clk); #1;
    chk("R8 capture gap", gap, 0);
    mot_valid = 0; load_valid = 0;
    m_origin = 700;
    pair(710, 30, "R8 after origin");
    chk("R8 relative", gap, 10);
    pair(800, 0, "R8 disarmed zero angle");
    chk("R8 no recapture", gap, -200);
    for (int m = 600; m <= 800; m += 13) pair(m, m & 255, "R8 sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule